// File: doc/BRIEF.md
# Display border flag unit

This block keeps the two flags that decide whether the border colour covers the picture. The vertical flag covers whole lines above and below the display window. The main flag covers the left and right margins, and it covers the whole line whenever the vertical flag is still set when the left edge is reached. The block is clocked once per video cycle. It takes the current raster line, the 1-based cycle number within the line, and three mode bits: row-select (25 or 24 text rows), column-select (40 or 38 columns) and display enable.

The vertical flag does not change straight away at the bottom line. A pending-set flag is raised there, and the live vertical flag copies it only at the start of a line or at the left edge. Reaching the top line with display enable high clears both flags at once. Which lines and cycles count as edges depends on the row-select and column-select bits. All line and cycle values are parameters.

Top module: `border_flags`

## Requirements
- R1: While rst_ni is low, and on the first cycle after reset, vborder_o and main_border_o are both 1, and the pending-set flag is 1.
- R2: When line_i equals the top line (51 if rows25_i=1, 55 if rows25_i=0) and display_en_i=1, the vertical flag and the pending-set flag are cleared. vborder_o is 0 after that clock edge, in every cycle of the line.
- R3: With display_en_i=0 the top line clears nothing. In a cycle that is neither cycle 1 nor the left cycle, vborder_o keeps its value.
- R4: When line_i equals the bottom line (251 if rows25_i=1, 247 if rows25_i=0), the pending-set flag is set in any cycle. vborder_o does not rise until the next cycle 1 or left cycle.
- R5: In cycle 1, the vertical flag takes the pending-set flag, after that cycle's top and bottom checks have been applied.
- R6: In the left cycle (17 if cols40_i=1, 18 if cols40_i=0), the bottom check is applied first and the vertical flag then takes the pending-set flag. If the resulting vertical flag is 0, main_border_o is cleared.
- R7: In the left cycle, if the resulting vertical flag is 1, main_border_o keeps its value.
- R8: In the right cycle (56 if cols40_i=0, 57 if cols40_i=1), main_border_o is set. In any cycle other than the left and right cycles it keeps its value.
- R9: The row-select bit chooses between the two pairs of top and bottom lines, and the column-select bit chooses between the two pairs of left and right cycles. The line or cycle of the pair not chosen has no effect.
- R10: The top and bottom comparisons are evaluated in every cycle of a line, not only in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 9 | Current raster line |
| cycle_i | input | 7 | Current cycle within the line, 1-based |
| rows25_i | input | 1 | Row-select: 1 for 25 rows, 0 for 24 rows |
| cols40_i | input | 1 | Column-select: 1 for 40 columns, 0 for 38 columns |
| display_en_i | input | 1 | Display enable; gates the top-line comparison |
| vborder_o | output | 1 | Vertical border flag |
| main_border_o | output | 1 | Main border flag |

## Verification
The assertions assume that the inputs stay constant for a whole clock and are sampled at the rising edge. They also assume that the top line is below the bottom line, so that the two comparisons never match on the same line. The properties hold for any sequence of cycle numbers, so the stimulus does not need to step through the cycles in order. It draws the line from a pool weighted towards the four edge lines and picks cycle numbers that often land on 1, 17, 18, 56 and 57. It keeps the line within 0 to 311, so a 9-bit line never aliases onto an edge line.

// File: rtl/border_pkg.sv
package border_pkg;
  typedef struct packed {
    logic top_hit;    // top line match, already gated by display enable
    logic bot_hit;    // bottom line match
    logic line_start; // cycle 1
    logic left_hit;   // left edge cycle
    logic right_hit;  // right edge cycle
  } brd_hits_t;
endpackage

// File: rtl/border_cmp.sv
module border_cmp
  import border_pkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int CYC_W       = 7,
  parameter int TOP_25      = 51,
  parameter int TOP_24      = 55,
  parameter int BOT_25      = 251,
  parameter int BOT_24      = 247,
  parameter int LEFT_40     = 17,
  parameter int LEFT_38     = 18,
  parameter int RIGHT_40    = 57,
  parameter int RIGHT_38    = 56,
  parameter int START_CYC   = 1
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic              rows25_i,
  input  logic              cols40_i,
  input  logic              display_en_i,
  output brd_hits_t         hits_o
);
  localparam logic [LINE_W-1:0] T25 = LINE_W'(TOP_25);
  localparam logic [LINE_W-1:0] T24 = LINE_W'(TOP_24);
  localparam logic [LINE_W-1:0] B25 = LINE_W'(BOT_25);
  localparam logic [LINE_W-1:0] B24 = LINE_W'(BOT_24);
  localparam logic [CYC_W-1:0]  L40 = CYC_W'(LEFT_40);
  localparam logic [CYC_W-1:0]  L38 = CYC_W'(LEFT_38);
  localparam logic [CYC_W-1:0]  R40 = CYC_W'(RIGHT_40);
  localparam logic [CYC_W-1:0]  R38 = CYC_W'(RIGHT_38);
  localparam logic [CYC_W-1:0]  S1  = CYC_W'(START_CYC);

  logic [LINE_W-1:0] top_line, bot_line;
  logic [CYC_W-1:0]  left_cyc, right_cyc;

  always_comb begin
    top_line  = rows25_i ? T25 : T24;
    bot_line  = rows25_i ? B25 : B24;
    left_cyc  = cols40_i ? L40 : L38;
    right_cyc = cols40_i ? R40 : R38;
    hits_o.top_hit    = (line_i == top_line) && display_en_i;
    hits_o.bot_hit    = (line_i == bot_line);
    hits_o.line_start = (cycle_i == S1);
    hits_o.left_hit   = (cycle_i == left_cyc);
    hits_o.right_hit  = (cycle_i == right_cyc);
  end
endmodule

// File: rtl/vborder_ff.sv
module vborder_ff
  import border_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  brd_hits_t hits_i,
  output logic      vert_o,
  output logic      left_vert_o
);
  logic pend_q, vert_q, pend_d, vert_d;

  always_comb begin
    pend_d = pend_q;
    vert_d = vert_q;
    // left edge: bottom check first, then copy pending
    if (hits_i.left_hit) begin
      pend_d = pend_d | hits_i.bot_hit;
      vert_d = pend_d;
    end
    left_vert_o = vert_d;
    if (hits_i.top_hit) begin
      vert_d = 1'b0;
      pend_d = 1'b0;
    end
    if (hits_i.bot_hit) pend_d = 1'b1;
    if (hits_i.line_start) vert_d = pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
      vert_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      vert_q <= vert_d;
    end
  end

  assign vert_o = vert_q;
endmodule

// File: rtl/mborder_ff.sv
module mborder_ff
  import border_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  brd_hits_t hits_i,
  input  logic      left_vert_i,
  output logic      main_o
);
  logic main_q, main_d;

  always_comb begin
    main_d = main_q;
    if (hits_i.left_hit && !left_vert_i) main_d = 1'b0;
    if (hits_i.right_hit) main_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) main_q <= 1'b1;
    else         main_q <= main_d;
  end

  assign main_o = main_q;
endmodule

// File: rtl/border_flags.sv
module border_flags
  import border_pkg::*;
#(
  parameter int LINE_W   = 9,
  parameter int CYC_W    = 7,
  parameter int TOP_25   = 51,
  parameter int TOP_24   = 55,
  parameter int BOT_25   = 251,
  parameter int BOT_24   = 247,
  parameter int LEFT_40  = 17,
  parameter int LEFT_38  = 18,
  parameter int RIGHT_40 = 57,
  parameter int RIGHT_38 = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic              rows25_i,
  input  logic              cols40_i,
  input  logic              display_en_i,
  output logic              vborder_o,
  output logic              main_border_o
);
  brd_hits_t hits;
  logic      left_vert;

  border_cmp #(
    .LINE_W(LINE_W), .CYC_W(CYC_W),
    .TOP_25(TOP_25), .TOP_24(TOP_24), .BOT_25(BOT_25), .BOT_24(BOT_24),
    .LEFT_40(LEFT_40), .LEFT_38(LEFT_38), .RIGHT_40(RIGHT_40), .RIGHT_38(RIGHT_38),
    .START_CYC(1)
  ) i_cmp (
    .line_i(line_i), .cycle_i(cycle_i), .rows25_i(rows25_i),
    .cols40_i(cols40_i), .display_en_i(display_en_i), .hits_o(hits)
  );

  vborder_ff i_vert (
    .clk_i(clk_i), .rst_ni(rst_ni), .hits_i(hits),
    .vert_o(vborder_o), .left_vert_o(left_vert)
  );

  mborder_ff i_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .hits_i(hits),
    .left_vert_i(left_vert), .main_o(main_border_o)
  );
endmodule

// File: rtl/border_flags_chk.sv
module border_flags_chk #(
  parameter int LINE_W   = 9,
  parameter int CYC_W    = 7,
  parameter int TOP_25   = 51,
  parameter int TOP_24   = 55,
  parameter int LEFT_40  = 17,
  parameter int LEFT_38  = 18,
  parameter int RIGHT_40 = 57,
  parameter int RIGHT_38 = 56
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINE_W-1:0] line_i,
  input logic [CYC_W-1:0]  cycle_i,
  input logic              rows25_i,
  input logic              cols40_i,
  input logic              display_en_i,
  input logic              vborder_o,
  input logic              main_border_o
);
  logic at_top, at_left, at_right, at_start;
  assign at_top   = (int'(line_i) == (rows25_i ? TOP_25 : TOP_24)) && display_en_i;
  assign at_left  = (int'(cycle_i) == (cols40_i ? LEFT_40 : LEFT_38));
  assign at_right = (int'(cycle_i) == (cols40_i ? RIGHT_40 : RIGHT_38));
  assign at_start = (int'(cycle_i) == 1);

  AST_TOP_CLEARS_VERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_top |=> !vborder_o); // R2
  AST_VERT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!display_en_i && !at_start && !at_left) |=> $stable(vborder_o)); // R3
  AST_VERT_RISE_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vborder_o) |-> $past(at_start || at_left)); // R5
  AST_MAIN_FALL_AT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_border_o) |-> ($past(at_left) && !vborder_o)); // R6
  AST_RIGHT_SETS_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_right |=> main_border_o); // R8
  AST_MAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_left && !at_right) |=> $stable(main_border_o)); // R8
endmodule

bind border_flags border_flags_chk #(
  .LINE_W(LINE_W), .CYC_W(CYC_W), .TOP_25(TOP_25), .TOP_24(TOP_24),
  .LEFT_40(LEFT_40), .LEFT_38(LEFT_38), .RIGHT_40(RIGHT_40), .RIGHT_38(RIGHT_38)
) i_border_flags_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .cycle_i(cycle_i),
  .rows25_i(rows25_i), .cols40_i(cols40_i), .display_en_i(display_en_i),
  .vborder_o(vborder_o), .main_border_o(main_border_o)
);

// File: tb/test_border_flags.sv
module test_border_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] line = '0;
  logic [6:0] cyc = '0;
  logic       rows25 = 1'b1, cols40 = 1'b1, den = 1'b0;
  logic       vb, mb;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  bit m_pend, m_vert, m_main;

  always #(CLK_PERIOD/2) clk = ~clk;

  border_flags i_border_flags (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .cycle_i(cyc),
    .rows25_i(rows25), .cols40_i(cols40), .display_en_i(den),
    .vborder_o(vb), .main_border_o(mb)
  );

  function automatic int top_of(bit r); return r ? 51 : 55; endfunction
  function automatic int bot_of(bit r); return r ? 251 : 247; endfunction
  function automatic int left_of(bit c); return c ? 17 : 18; endfunction
  function automatic int right_of(bit c); return c ? 57 : 56; endfunction

  // reference: one video cycle of the requirements
  task automatic model_step();
    bit bot = (int'(line) == bot_of(rows25));
    bit top = (int'(line) == top_of(rows25)) && den;
    if (int'(cyc) == left_of(cols40)) begin        // R6, R7
      if (bot) m_pend = 1;
      m_vert = m_pend;
      if (!m_vert) m_main = 0;
    end
    if (int'(cyc) == right_of(cols40)) m_main = 1;  // R8
    if (top) begin m_vert = 0; m_pend = 0; end      // R2, R10
    if (bot) m_pend = 1;                            // R4
    if (int'(cyc) == 1) m_vert = m_pend;            // R5
  endtask

  function automatic string tag_of();
    if (int'(cyc) == left_of(cols40)) return "R6";
    if (int'(cyc) == right_of(cols40)) return "R8";
    if (int'(cyc) == 1) return "R5";
    if (int'(line) == top_of(rows25)) return den ? "R2" : "R3";
    if (int'(line) == bot_of(rows25)) return "R4";
    return "R10";
  endfunction

  task automatic check(string tag);
    n_vec++;
    if (vb !== m_vert || mb !== m_main) begin
      n_bad++;
      $display("FAIL %s: line=%0d cyc=%0d vborder=%b main=%b expected vborder=%b main=%b",
               tag, line, cyc, vb, mb, m_vert, m_main);
    end
  endtask

  task automatic apply(int l, int c, bit r, bit co, bit d, string tag);
    @(negedge clk);
    line = 9'(l); cyc = 7'(c); rows25 = r; cols40 = co; den = d;
    @(posedge clk);
    model_step();
    #1;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int pool;
    m_pend = 1; m_vert = 1; m_main = 1;
    repeat (3) @(negedge clk);
    #1; check("R1");
    rst_n = 1'b1;
    apply(100, 30, 1, 1, 1, "R1");
    // R3: top line with display disabled clears nothing mid-line
    apply(51, 30, 1, 1, 0, "R3");
    apply(51, 17, 1, 1, 0, "R3");
    // R2/R10: top line mid-line with enable clears vertical flag
    apply(51, 40, 1, 1, 1, "R2");
    apply(51, 41, 1, 1, 0, "R10");
    // R6: left cycle with flag clear drops main
    apply(52, 17, 1, 1, 1, "R6");
    // R8: right cycle sets main, narrow columns -> 56
    apply(52, 57, 1, 0, 1, "R9");
    apply(52, 56, 1, 0, 1, "R8");
    // R4: bottom mid-line sets pending, no immediate rise
    apply(251, 30, 1, 1, 1, "R4");
    apply(251, 31, 1, 1, 1, "R4");
    apply(251, 1, 1, 1, 1, "R5");
    // R7: left cycle with flag set keeps main
    apply(252, 18, 1, 0, 1, "R7");
    // R9: 24-row top is 55, not 51
    apply(51, 5, 0, 1, 1, "R9");
    apply(55, 5, 0, 1, 1, "R9");
    apply(56, 18, 0, 0, 1, "R6");
    // R9: 24-row bottom is 247, 251 ignored
    apply(251, 18, 0, 0, 1, "R9");
    apply(247, 18, 0, 0, 1, "R6");
    void'($urandom(32'h5eed_b0de));
    for (int i = 0; i < 4000; i++) begin
      int l, c;
      pool = $urandom_range(0, 9);
      case (pool)
        0: l = 51; 1: l = 55; 2: l = 251; 3: l = 247;
        default: l = $urandom_range(0, 311);
      endcase
      pool = $urandom_range(0, 9);
      case (pool)
        0: c = 1; 1: c = 17; 2: c = 18; 3: c = 56; 4: c = 57;
        default: c = $urandom_range(0, 63);
      endcase
      @(negedge clk);
      line = 9'(l); cyc = 7'(c);
      rows25 = ($urandom_range(0, 7) != 0);
      cols40 = ($urandom_range(0, 7) != 0);
      den = ($urandom_range(0, 3) != 0);
      @(posedge clk);
      model_step();
      #1;
      check(tag_of());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule